// File: doc/BRIEF.md
# Coulomb Charge Counter

This block integrates current over time for a current-only measurement channel. Once per 200 ms measurement window, the upstream RMS stage presents one RMS current value in milliamps, together with a one-cycle strobe. A window of 200 ms is 1/18000 of an hour. The block therefore adds the window's milliamp value divided by 1800 to a running charge total, in units of 0.1 mA·h. It also counts how many windows have been taken, so that a host can later form an average current from the two totals.

The division by 1800 is exact over any number of windows. A remainder register, always below 1800, keeps the fractional part of each window. Each window adds its milliamp value to that remainder, and every whole multiple of 1800 moves into the charge total. The charge total therefore always equals the integer part of the summed milliamp values divided by 1800, with no truncation loss per window. Both totals stop at all-ones instead of wrapping.

A command port carries a command code with a valid strobe. Only the charge-clear code 0x05 has an effect: it zeroes the charge total, the window count and the remainder. When a clear and a window strobe arrive in the same cycle, the clear wins and that window is dropped. The totals are volatile and are zero after reset.

Top module: `coulomb_accum`

## Requirements
- R1: After reset, `charge_q` and `window_cnt` read 0, and the remainder is 0.
- R2: After any sequence of windows since the last clear, `charge_q` equals floor(S / 1800), where S is the sum of the accepted `win_ma` values. The remainder carried between windows always stays below 1800.
- R3: Each accepted window raises `window_cnt` by exactly one, whatever its current value (zero included).
- R4: `cmd_valid` high with `cmd_code` equal to 0x05 sets `charge_q`, `window_cnt` and the remainder to 0 on the next clock edge.
- R5: A command with any other code, or code 0x05 with `cmd_valid` low, leaves both totals and the remainder unchanged.
- R6: When a clear and `win_valid` fall in the same cycle, the clear takes effect and the window is discarded: both totals read 0 afterwards.
- R7: A steady 10000 mA input over 9 windows raises `charge_q` by exactly 50.
- R8: The outputs are registered. They change on the clock edge that samples the strobe or the clear, and otherwise hold their value.
- R9: `charge_q` and `window_cnt` saturate at all ones and never wrap. This holds for any configured output width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| win_valid | input | 1 | One-cycle strobe marking the end of a measurement window |
| win_ma | input | MA_W (16) | RMS current of the window in mA, unsigned |
| cmd_valid | input | 1 | Strobe qualifying `cmd_code` |
| cmd_code | input | CMD_W (8) | Command code; 0x05 clears the counter |
| charge_q | output | CHG_W (32) | Accumulated charge in 0.1 mA·h |
| window_cnt | output | CNT_W (32) | Number of windows accumulated |

## Verification
Two functions can land in the same cycle: the clear command and a window strobe. The bench raises both together in directed cases, once with a remainder already pending. Its random mix also picks cycles with both strobes set. Each such collision is judged by the zero totals right after it, and by the next window starting from a zero remainder. Saturation uses a second instance with narrow outputs, driven by full-scale windows until both totals pin at all ones.

// File: rtl/coulomb_pkg.sv
package coulomb_pkg;

  // Whole multiples of the divisor in (rem + add)
  function automatic logic [31:0] div_quo(input logic [31:0] rem,
                                          input logic [31:0] add,
                                          input logic [31:0] divisor);
    logic [31:0] total;
    total = rem + add;
    return total / divisor;
  endfunction

  // Fraction left over after moving whole multiples out
  function automatic logic [31:0] div_rem(input logic [31:0] rem,
                                          input logic [31:0] add,
                                          input logic [31:0] divisor);
    logic [31:0] total;
    total = rem + add;
    return total % divisor;
  endfunction

  // Addition clamped at lim (inc assumed <= lim)
  function automatic logic [63:0] sat_add(input logic [63:0] base,
                                          input logic [63:0] inc,
                                          input logic [63:0] lim);
    if (inc > lim - base) return lim;
    return base + inc;
  endfunction

endpackage

// File: rtl/coulomb_cmd_decode.sv
module coulomb_cmd_decode #(
  parameter int CMD_W = 8,
  parameter logic [CMD_W-1:0] CLR_CODE = 'h05
) (
  input  logic             cmd_valid,
  input  logic [CMD_W-1:0] cmd_code,
  output logic             clear_hit
);
  assign clear_hit = cmd_valid && (cmd_code == CLR_CODE);
endmodule

// File: rtl/coulomb_rem_div.sv
module coulomb_rem_div #(
  parameter int MA_W    = 16,
  parameter int DIVISOR = 1800,
  parameter int REM_W   = 11,
  parameter int QUO_W   = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             take,
  input  logic [MA_W-1:0]  ma,
  output logic [QUO_W-1:0] carry,
  output logic [REM_W-1:0] rem_q
);
  import coulomb_pkg::*;

  logic [REM_W-1:0] rem_nxt;

  assign carry   = QUO_W'(div_quo(32'(rem_q), 32'(ma), 32'(DIVISOR)));
  assign rem_nxt = REM_W'(div_rem(32'(rem_q), 32'(ma), 32'(DIVISOR)));

  always_ff @(posedge clk) begin
    if (!rst_n)      rem_q <= '0;
    else if (clear)  rem_q <= '0;
    else if (take)   rem_q <= rem_nxt;
  end
endmodule

// File: rtl/coulomb_sat_cnt.sv
module coulomb_sat_cnt #(
  parameter int W     = 32,
  parameter int INC_W = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             take,
  input  logic [INC_W-1:0] inc,
  output logic [W-1:0]     value_q
);
  import coulomb_pkg::*;

  localparam logic [W-1:0] MAXV = '1;

  always_ff @(posedge clk) begin
    if (!rst_n)      value_q <= '0;
    else if (clear)  value_q <= '0;
    else if (take)   value_q <= W'(sat_add(64'(value_q), 64'(inc), 64'(MAXV)));
  end
endmodule

// File: rtl/coulomb_accum.sv
module coulomb_accum #(
  parameter int MA_W    = 16,
  parameter int CHG_W   = 32,
  parameter int CNT_W   = 32,
  parameter int DIVISOR = 1800,
  parameter int CMD_W   = 8,
  parameter logic [CMD_W-1:0] CLR_CODE = 'h05
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             win_valid,
  input  logic [MA_W-1:0]  win_ma,
  input  logic             cmd_valid,
  input  logic [CMD_W-1:0] cmd_code,
  output logic [CHG_W-1:0] charge_q,
  output logic [CNT_W-1:0] window_cnt
);
  localparam int REM_W   = $clog2(DIVISOR);
  localparam int QUO_MAX = ((2 ** MA_W) - 1 + DIVISOR - 1) / DIVISOR;
  localparam int QUO_W   = $clog2(QUO_MAX + 1);

  logic             clear_hit;
  logic             win_take;
  logic [QUO_W-1:0] carry_q;
  logic [REM_W-1:0] rem_now;

  coulomb_cmd_decode #(.CMD_W(CMD_W), .CLR_CODE(CLR_CODE)) u_dec (
    .cmd_valid (cmd_valid),
    .cmd_code  (cmd_code),
    .clear_hit (clear_hit)
  );

  // clear has priority: a coinciding window is dropped
  assign win_take = win_valid && !clear_hit;

  coulomb_rem_div #(.MA_W(MA_W), .DIVISOR(DIVISOR), .REM_W(REM_W), .QUO_W(QUO_W)) u_rem (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (clear_hit),
    .take  (win_take),
    .ma    (win_ma),
    .carry (carry_q),
    .rem_q (rem_now)
  );

  coulomb_sat_cnt #(.W(CHG_W), .INC_W(QUO_W)) u_chg (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (clear_hit),
    .take    (win_take),
    .inc     (carry_q),
    .value_q (charge_q)
  );

  coulomb_sat_cnt #(.W(CNT_W), .INC_W(1)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (clear_hit),
    .take    (win_take),
    .inc     (1'b1),
    .value_q (window_cnt)
  );
endmodule

// File: rtl/coulomb_accum_chk.sv
module coulomb_accum_chk #(
  parameter int CHG_W   = 32,
  parameter int CNT_W   = 32,
  parameter int DIVISOR = 1800,
  parameter int CMD_W   = 8,
  parameter int REM_W   = 11,
  parameter logic [CMD_W-1:0] CLR_CODE = 'h05
) (
  input logic             clk,
  input logic             rst_n,
  input logic             win_valid,
  input logic             cmd_valid,
  input logic [CMD_W-1:0] cmd_code,
  input logic             clear_hit,
  input logic             win_take,
  input logic [REM_W-1:0] rem_now,
  input logic [CHG_W-1:0] charge_q,
  input logic [CNT_W-1:0] window_cnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  AST_REM_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    32'(rem_now) < DIVISOR); // R2

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    win_take && (window_cnt != CNT_MAX) |=> window_cnt == $past(window_cnt) + CNT_W'(1)); // R3

  AST_CLEAR_ZEROS: assert property (@(posedge clk) disable iff (!rst_n)
    clear_hit |=> (charge_q == '0) && (window_cnt == '0) && (rem_now == '0)); // R4

  AST_OTHER_CODE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && (cmd_code != CLR_CODE) && !win_valid
      |=> $stable(charge_q) && $stable(window_cnt) && $stable(rem_now)); // R5

  AST_CLEAR_BEATS_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    clear_hit && win_valid |=> window_cnt == '0); // R6

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !win_valid && !clear_hit |=> $stable(charge_q) && $stable(window_cnt)); // R8

  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    !clear_hit |=> (charge_q >= $past(charge_q)) && (window_cnt >= $past(window_cnt))); // R9
endmodule

bind coulomb_accum coulomb_accum_chk #(
  .CHG_W(CHG_W), .CNT_W(CNT_W), .DIVISOR(DIVISOR),
  .CMD_W(CMD_W), .REM_W(REM_W), .CLR_CODE(CLR_CODE)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .win_valid  (win_valid),
  .cmd_valid  (cmd_valid),
  .cmd_code   (cmd_code),
  .clear_hit  (clear_hit),
  .win_take   (win_take),
  .rem_now    (rem_now),
  .charge_q   (charge_q),
  .window_cnt (window_cnt)
);

// File: tb/coulomb_accum_tb.sv
module coulomb_accum_tb_top;
  localparam int SW_CHG = 8;
  localparam int SW_CNT = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        win_valid = 1'b0;
  logic [15:0] win_ma = '0;
  logic        cmd_valid = 1'b0;
  logic [7:0]  cmd_code = '0;
  logic [31:0] charge_q, window_cnt;
  logic [SW_CHG-1:0] charge_s;
  logic [SW_CNT-1:0] count_s;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 0;

  longint unsigned sum_ma = 0;
  longint unsigned n_win  = 0;

  always #10 clk = ~clk;

  coulomb_accum dut_i (
    .clk(clk), .rst_n(rst_n), .win_valid(win_valid), .win_ma(win_ma),
    .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .charge_q(charge_q), .window_cnt(window_cnt)
  );

  coulomb_accum #(.CHG_W(SW_CHG), .CNT_W(SW_CNT)) dut_s (
    .clk(clk), .rst_n(rst_n), .win_valid(win_valid), .win_ma(win_ma),
    .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .charge_q(charge_s), .window_cnt(count_s)
  );

  // expected value: the total clamped at the width's all-ones
  function automatic longint unsigned clip(longint unsigned v, int w);
    longint unsigned lim;
    lim = (64'd1 << w) - 64'd1;
    return (v > lim) ? lim : v;
  endfunction

  function automatic longint unsigned exp_charge(longint unsigned s, int w);
    return clip(s / 64'd1800, w);
  endfunction

  task automatic finish_up();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  endtask

  task automatic check(string req);
    longint unsigned ec, en, ecs, ens;
    ec  = exp_charge(sum_ma, 32);
    en  = clip(n_win, 32);
    ecs = exp_charge(sum_ma, SW_CHG);
    ens = clip(n_win, SW_CNT);
    n_checks++;
    if (64'(charge_q) != ec || 64'(window_cnt) != en ||
        64'(charge_s) != ecs || 64'(count_s) != ens) begin
      n_fails++;
      $display("FAIL %s: charge=%0d cnt=%0d narrow charge=%0d cnt=%0d, expected %0d %0d %0d %0d",
               req, charge_q, window_cnt, charge_s, count_s, ec, en, ecs, ens);
    end
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic step(bit wv, logic [15:0] ma, bit cv, logic [7:0] code);
    win_valid = wv; win_ma = ma; cmd_valid = cv; cmd_code = code;
    @(negedge clk);
    win_valid = 1'b0; cmd_valid = 1'b0;
    if (cv && code == 8'h05) begin
      sum_ma = 0; n_win = 0;
    end else if (wv) begin
      sum_ma += 64'(ma); n_win++;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++; n_fails++;
    $display("FAIL watchdog: run did not complete, actual hung, expected done");
    finish_up();
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R1 reset state");

    step(1, 16'd1799, 0, 0); check("R2 below one unit");
    step(1, 16'd1, 0, 0);    check("R2 remainder carry");
    step(1, 16'd3601, 0, 0); check("R2 two units plus fraction");

    for (int i = 0; i < 9; i++) step(1, 16'd10000, 0, 0);
    check("R7 10 A over 9 windows");

    step(1, 16'd0, 0, 0); step(1, 16'd0, 0, 0);
    check("R3 zero-current windows counted");

    step(0, 0, 1, 8'h04); check("R5 other code ignored");
    step(0, 0, 0, 8'h05); check("R5 clear code without valid ignored");
    step(0, 0, 1, 8'h85); check("R5 code with high bit ignored");
    repeat (5) step(0, 16'hFFFF, 0, 0);
    check("R8 hold while idle");

    step(1, 16'd900, 0, 0);
    step(0, 0, 1, 8'h05); check("R4 clear zeroes totals");
    step(1, 16'd900, 0, 0); check("R4 remainder cleared");

    step(1, 16'd1700, 0, 0);
    step(1, 16'd5000, 1, 8'h05); check("R6 clear wins over window");
    step(1, 16'd100, 0, 0); check("R6 next window starts from zero remainder");

    step(0, 0, 1, 8'h05);
    for (int i = 0; i < 70; i++) step(1, 16'hFFFF, 0, 0);
    check("R9 narrow totals saturate");
    step(1, 16'hFFFF, 0, 0); check("R9 saturated totals stay");
    step(0, 0, 1, 8'h05); check("R4 clear from saturation");

    for (int i = 0; i < 400; i++) begin
      int unsigned sel;
      logic [15:0] ma;
      sel = $urandom % 16;
      case ($urandom % 4)
        0: ma = 16'hFFFF;
        1: ma = 16'(1800 * ($urandom % 37));
        default: ma = 16'($urandom);
      endcase
      if (sel == 0)      step(1, ma, 1, 8'h05);
      else if (sel == 1) step(0, ma, 1, 8'h05);
      else if (sel == 2) step(1, ma, 1, 8'($urandom));
      else if (sel < 5)  step(0, ma, 0, 0);
      else               step(1, ma, 0, 0);
      if (sel == 0) check("R6 random collision");
      else if (sel == 2) check("R5 random non-clear command");
      else check("R2 random mix");
    end

    finish_up();
  end
endmodule